// File: doc/BRIEF.md
# Interrupt Redirection Register File with Select/Window Access

This block stores the per-pin routing configuration of an interrupt router. Software reaches it through two 32-bit locations on a simple memory-mapped bus. It first writes an 8-bit index to the select location. It then reads or writes the window location, and that access lands on the register the index names.

Index 0x00 holds a 4-bit identifier. Index 0x02 mirrors the identifier but cannot be written. Index 0x01 is a read-only version word. From index 0x10 upward, each pair of indices covers one 64-bit redirection entry, one 32-bit half per index.

Each entry carries these fields:
- the interrupt vector
- the delivery mode
- the destination mode
- the polarity
- the trigger mode
- the mask
- the destination
- two status bits, a busy flag and a remote-IRR flag

The block drives all of these fields out per pin. A one-cycle strobe reports the entry number whenever software flips that entry's mask. The delivery logic around the block sets and clears the two status bits through dedicated per-pin pulses, and bus writes cannot change them.

Top module: `irq_redir_regs`

## Requirements
- R1: A write at bus offset 0x00 stores bits 7:0 of the write data as the index and ignores the upper bits. A read at offset 0x00 returns the index zero-extended to 32 bits.
- R2: Index 0x01 reads as (NUM_PINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Window writes at this index change nothing.
- R3: A window write at index 0x00 stores data bits 27:24 as the identifier. Indices 0x00 and 0x02 both read the identifier in bits 27:24 with all other bits zero. Window writes at index 0x02 are ignored.
- R4: For an index of 0x10 or more, the entry number is (index-0x10)>>1. An even index reaches entry bits 31:0 and an odd index reaches bits 63:32.
- R5: A window read returns 0xFFFFFFFF at indices 0x03 to 0x0F and at any index whose entry number is NUM_PINS or more. Window writes at those indices change no state.
- R6: A window write to an entry replaces only the 32-bit half it addresses. The other half keeps its value.
- R7: Entry bit 12 (busy status) and bit 14 (remote-IRR) are read-only from the bus and keep their values across window writes. They are set by the per-pin set pulses and cleared by the per-pin clear pulses, and a clear wins over a set in the same cycle.
- R8: When a window write leaves an entry's trigger bit 15 at 0 (edge), that entry's remote-IRR bit becomes 0 in the same update. A 1 in bit 15 means level.
- R9: After reset, each entry holds 0x0000000000010000 (only mask bit 16 set), and the index, the identifier and the status bits are zero.
- R10: When a window write flips an entry's mask bit 16, mask_chg_valid is 1 for exactly the next cycle and mask_chg_pin carries that entry number. A write that leaves the mask bit unchanged produces no strobe.
- R11: Bus offsets other than 0x00 and 0x10 read as zero, and writes to them change no state.
- R12: The per-pin outputs follow the entry layout: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, busy in 12, polarity in 13, remote-IRR in 14, trigger in 15, mask in 16 and destination in 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid during a read |
| rirr_set | input | NUM_PINS | Per-pin pulse that sets remote-IRR |
| rirr_clr | input | NUM_PINS | Per-pin pulse that clears remote-IRR |
| busy_set | input | NUM_PINS | Per-pin pulse that sets busy status |
| busy_clr | input | NUM_PINS | Per-pin pulse that clears busy status |
| pin_vector | output | NUM_PINS*8 | Vector per pin |
| pin_dlv_mode | output | NUM_PINS*3 | Delivery mode per pin |
| pin_dest_mode | output | NUM_PINS | Destination mode per pin |
| pin_busy | output | NUM_PINS | Busy status per pin |
| pin_polarity | output | NUM_PINS | Polarity per pin |
| pin_remote_irr | output | NUM_PINS | Remote-IRR per pin |
| pin_trigger | output | NUM_PINS | Trigger mode per pin, 1 = level |
| pin_mask | output | NUM_PINS | Mask per pin |
| pin_dest | output | NUM_PINS*8 | Destination per pin |
| mask_chg_valid | output | 1 | One-cycle mask-change strobe |
| mask_chg_pin | output | PIN_W | Entry number of the flipped mask |

## Verification
The bench attacks the status bits from several directions:
- It writes ones into bits 12 and 14. A design that let the bus reach them would read those bits back set.
- It rewrites a level entry while remote-IRR is set. If the edge clear fired on every write, remote-IRR would read back as zero.
- It switches the entry to edge. A design that skipped the clear would leave the flag stuck at one.

It also probes the index arithmetic at the last valid entry, the first out-of-range entry and the gap 0x03 to 0x0F. An off-by-one decode would alias a real entry there instead of returning all ones. Finally, it repeats a mask write with the same value to catch a strobe that fires on every write rather than only on a change.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Bus offsets
    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;

    // Index space behind the window
    localparam logic [7:0] IDX_IDENT  = 8'h00;
    localparam logic [7:0] IDX_VERS   = 8'h01;
    localparam logic [7:0] IDX_ARBIT  = 8'h02;
    localparam logic [7:0] IDX_TABLE  = 8'h10;

    // Entry field positions
    localparam int VEC_LSB   = 0;
    localparam int DLV_LSB   = 8;
    localparam int DMODE_BIT = 11;
    localparam int BUSY_BIT  = 12;
    localparam int POL_BIT   = 13;
    localparam int RIRR_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 56;

    localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        RK_IDENT,
        RK_VERS,
        RK_ARBIT,
        RK_ENTRY,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/redir_index_decode.sv
module redir_index_decode
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [7:0]       sel,
    output reg_kind_e        kind,
    output logic [PIN_W-1:0] pin,
    output logic             upper
);

    logic [7:0] rel;
    logic [6:0] ent;

    assign rel   = sel - IDX_TABLE;
    assign ent   = rel[7:1];
    assign pin   = ent[PIN_W-1:0];
    assign upper = sel[0];

    always_comb begin
        if (sel == IDX_IDENT)          kind = RK_IDENT;
        else if (sel == IDX_VERS)      kind = RK_VERS;
        else if (sel == IDX_ARBIT)     kind = RK_ARBIT;
        else if (sel < IDX_TABLE)      kind = RK_NONE;
        else if (int'(ent) < NUM_PINS) kind = RK_ENTRY;
        else                           kind = RK_NONE;
    end

endmodule

// File: rtl/redir_entry.sv
module redir_entry
    import irq_redir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        busy_set,
    input  logic        busy_clr,
    output logic [63:0] q,
    output logic        mask_flip
);

    logic [63:0] nxt;
    logic        wr_any;

    assign wr_any    = wr_lo | wr_hi;
    assign mask_flip = wr_lo && (wdata[MASK_BIT] != q[MASK_BIT]);

    always_comb begin
        nxt = q;
        if (wr_lo) nxt[31:0]  = wdata;
        if (wr_hi) nxt[63:32] = wdata;
        // status bits are not reachable from the bus
        nxt[BUSY_BIT] = q[BUSY_BIT];
        nxt[RIRR_BIT] = q[RIRR_BIT];
        if (busy_set) nxt[BUSY_BIT] = 1'b1;
        if (busy_clr) nxt[BUSY_BIT] = 1'b0;
        if (rirr_set) nxt[RIRR_BIT] = 1'b1;
        if (rirr_clr) nxt[RIRR_BIT] = 1'b0;
        // an entry left at edge trigger drops its remote-IRR
        if (wr_any && !nxt[TRIG_BIT]) nxt[RIRR_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENTRY_RESET;
        else        q <= nxt;
    end

    // R6
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (q[63:32] == $past(q[63:32])));

    // R7
    busy_survives_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !busy_set && !busy_clr) |=> (q[BUSY_BIT] == $past(q[BUSY_BIT])));

    // R8
    edge_drops_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> (q[TRIG_BIT] || !q[RIRR_BIT]));

    // R7
    rirr_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rirr_clr |=> !q[RIRR_BIT]);

endmodule

// File: rtl/redir_read_mux.sv
module redir_read_mux
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  reg_kind_e                  kind,
    input  logic [PIN_W-1:0]           pin,
    input  logic                       upper,
    input  logic [3:0]                 ident,
    input  logic [NUM_PINS-1:0][63:0]  entries,
    output logic [31:0]                word
);

    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    logic [63:0] picked;

    assign picked = entries[pin];

    always_comb begin
        unique case (kind)
            RK_IDENT, RK_ARBIT: word = {4'h0, ident, 24'h0};
            RK_VERS:            word = {8'h00, LAST_PIN, 8'h00, VERSION};
            RK_ENTRY:           word = upper ? picked[63:32] : picked[31:0];
            default:            word = 32'hFFFF_FFFF;
        endcase
    end

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter int         BUS_AW   = 8,
    parameter logic [7:0] VERSION  = 8'h11,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_PINS-1:0]     rirr_set,
    input  logic [NUM_PINS-1:0]     rirr_clr,
    input  logic [NUM_PINS-1:0]     busy_set,
    input  logic [NUM_PINS-1:0]     busy_clr,
    output logic [NUM_PINS*8-1:0]   pin_vector,
    output logic [NUM_PINS*3-1:0]   pin_dlv_mode,
    output logic [NUM_PINS-1:0]     pin_dest_mode,
    output logic [NUM_PINS-1:0]     pin_busy,
    output logic [NUM_PINS-1:0]     pin_polarity,
    output logic [NUM_PINS-1:0]     pin_remote_irr,
    output logic [NUM_PINS-1:0]     pin_trigger,
    output logic [NUM_PINS-1:0]     pin_mask,
    output logic [NUM_PINS*8-1:0]   pin_dest,
    output logic                    mask_chg_valid,
    output logic [PIN_W-1:0]        mask_chg_pin
);

    localparam logic [BUS_AW-1:0] A_SEL = BUS_AW'(OFF_SELECT);
    localparam logic [BUS_AW-1:0] A_WIN = BUS_AW'(OFF_WINDOW);

    logic [7:0]                 sel_q;
    logic [3:0]                 ident_q;
    logic                       sel_we;
    logic                       win_we;
    logic                       rd_en;
    reg_kind_e                  kind;
    logic [PIN_W-1:0]           dec_pin;
    logic                       dec_upper;
    logic [NUM_PINS-1:0][63:0]  entries;
    logic [NUM_PINS-1:0]        flips;
    logic [31:0]                win_word;

    assign sel_we = bus_valid && bus_write && (bus_addr == A_SEL);
    assign win_we = bus_valid && bus_write && (bus_addr == A_WIN);
    assign rd_en  = bus_valid && !bus_write;

    redir_index_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .sel   (sel_q),
        .kind  (kind),
        .pin   (dec_pin),
        .upper (dec_upper)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 8'h00;
            ident_q <= 4'h0;
        end else begin
            if (sel_we) sel_q <= bus_wdata[7:0];
            if (win_we && kind == RK_IDENT) ident_q <= bus_wdata[27:24];
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic hit;
        assign hit = win_we && (kind == RK_ENTRY) && (dec_pin == PIN_W'(g));

        redir_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit && !dec_upper),
            .wr_hi     (hit && dec_upper),
            .wdata     (bus_wdata),
            .rirr_set  (rirr_set[g]),
            .rirr_clr  (rirr_clr[g]),
            .busy_set  (busy_set[g]),
            .busy_clr  (busy_clr[g]),
            .q         (entries[g]),
            .mask_flip (flips[g])
        );

        assign pin_vector[g*8 +: 8]   = entries[g][VEC_LSB +: 8];
        assign pin_dlv_mode[g*3 +: 3] = entries[g][DLV_LSB +: 3];
        assign pin_dest_mode[g]       = entries[g][DMODE_BIT];
        assign pin_busy[g]            = entries[g][BUSY_BIT];
        assign pin_polarity[g]        = entries[g][POL_BIT];
        assign pin_remote_irr[g]      = entries[g][RIRR_BIT];
        assign pin_trigger[g]         = entries[g][TRIG_BIT];
        assign pin_mask[g]            = entries[g][MASK_BIT];
        assign pin_dest[g*8 +: 8]     = entries[g][DEST_LSB +: 8];
    end

    // Only one entry can be written per cycle, so the decoded pin names the flip.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
        end else begin
            mask_chg_valid <= |flips;
            mask_chg_pin   <= dec_pin;
        end
    end

    redir_read_mux #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_rmux (
        .kind    (kind),
        .pin     (dec_pin),
        .upper   (dec_upper),
        .ident   (ident_q),
        .entries (entries),
        .word    (win_word)
    );

    always_comb begin
        bus_rdata = 32'h0;
        if (rd_en) begin
            if (bus_addr == A_SEL)      bus_rdata = {24'h0, sel_q};
            else if (bus_addr == A_WIN) bus_rdata = win_word;
        end
    end

    // R1
    sel_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel_q == $past(bus_wdata[7:0])));

    // R3
    arbit_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && kind == RK_ARBIT) |=> $stable(ident_q));

    // R5
    oor_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && kind == RK_NONE) |=> ($stable(pin_mask) && $stable(ident_q)));

    // R10
    strobe_matches_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> ((pin_mask ^ $past(pin_mask)) == (NUM_PINS'(1) << mask_chg_pin)));

    // R10
    no_strobe_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_chg_valid |-> (pin_mask == $past(pin_mask)));

    // R11
    other_offset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr != A_SEL && bus_addr != A_WIN)
            |=> ($stable(sel_q) && $stable(ident_q)));

endmodule

// File: tb/irq_redir_regs_tb.sv
module irq_redir_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP    = 24;
    localparam int PIN_W = $clog2(NP);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [7:0]        bus_addr = 8'h00;
    logic [31:0]       bus_wdata = 32'h0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP-1:0]     rirr_clr = '0;
    logic [NP-1:0]     busy_set = '0;
    logic [NP-1:0]     busy_clr = '0;
    logic [NP*8-1:0]   pin_vector;
    logic [NP*3-1:0]   pin_dlv_mode;
    logic [NP-1:0]     pin_dest_mode;
    logic [NP-1:0]     pin_busy;
    logic [NP-1:0]     pin_polarity;
    logic [NP-1:0]     pin_remote_irr;
    logic [NP-1:0]     pin_trigger;
    logic [NP-1:0]     pin_mask;
    logic [NP*8-1:0]   pin_dest;
    logic              mask_chg_valid;
    logic [PIN_W-1:0]  mask_chg_pin;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_redir_regs #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .busy_set(busy_set), .busy_clr(busy_clr),
        .pin_vector(pin_vector), .pin_dlv_mode(pin_dlv_mode),
        .pin_dest_mode(pin_dest_mode), .pin_busy(pin_busy),
        .pin_polarity(pin_polarity), .pin_remote_irr(pin_remote_irr),
        .pin_trigger(pin_trigger), .pin_mask(pin_mask), .pin_dest(pin_dest),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'hABCDEF01, 8'd1},  // R1 upper bits dropped
        '{1'b1, 8'h00, 32'h00000001, 8'd1},  // R1
        '{1'b1, 8'h10, 32'h00170011, 8'd2},  // R2 version word
        '{1'b0, 8'h10, 32'hFFFFFFFF, 8'd2},  // R2 write ignored
        '{1'b1, 8'h10, 32'h00170011, 8'd2},  // R2
        '{1'b0, 8'h00, 32'h00000000, 8'd3},
        '{1'b0, 8'h10, 32'hF5A5A5A5, 8'd3},  // R3 identifier = 5
        '{1'b1, 8'h10, 32'h05000000, 8'd3},  // R3
        '{1'b0, 8'h00, 32'h00000002, 8'd3},
        '{1'b1, 8'h10, 32'h05000000, 8'd3},  // R3 mirror
        '{1'b0, 8'h10, 32'h0C000000, 8'd3},  // R3 mirror write ignored
        '{1'b1, 8'h10, 32'h05000000, 8'd3},  // R3
        '{1'b0, 8'h00, 32'h00000012, 8'd4},
        '{1'b0, 8'h10, 32'h0000B234, 8'd7},  // R7 bit12 written as 1
        '{1'b1, 8'h10, 32'h0000A234, 8'd7},  // R7 bit12 stays 0
        '{1'b0, 8'h00, 32'h00000013, 8'd4},
        '{1'b0, 8'h10, 32'h7E000000, 8'd4},
        '{1'b1, 8'h10, 32'h7E000000, 8'd4},  // R4 odd index upper half
        '{1'b0, 8'h00, 32'h00000012, 8'd6},
        '{1'b1, 8'h10, 32'h0000A234, 8'd6},  // R6 low half kept
        '{1'b0, 8'h00, 32'h0000003F, 8'd4},
        '{1'b0, 8'h10, 32'hAA000000, 8'd4},
        '{1'b1, 8'h10, 32'hAA000000, 8'd4},  // R4 last entry
        '{1'b0, 8'h00, 32'h0000003E, 8'd9},
        '{1'b1, 8'h10, 32'h00010000, 8'd9},  // R9 reset value of entry
        '{1'b0, 8'h00, 32'h00000040, 8'd5},
        '{1'b0, 8'h10, 32'h00000000, 8'd5},  // R5 write beyond table
        '{1'b1, 8'h10, 32'hFFFFFFFF, 8'd5},  // R5
        '{1'b0, 8'h00, 32'h00000005, 8'd5},
        '{1'b1, 8'h10, 32'hFFFFFFFF, 8'd5},  // R5 gap index
        '{1'b1, 8'h04, 32'h00000000, 8'd11}, // R11
        '{1'b0, 8'h04, 32'h00000077, 8'd11}, // R11 write ignored
        '{1'b1, 8'h00, 32'h00000005, 8'd11}, // R11 index unchanged
        '{1'b1, 8'h20, 32'h00000000, 8'd11}  // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_valid = 1'b0;
    endtask

    task automatic pulse_status(input int which, input int pin);
        @(negedge clk);
        case (which)
            0: rirr_set[pin] = 1'b1;
            1: busy_set[pin] = 1'b1;
            default: begin busy_set[pin] = 1'b1; busy_clr[pin] = 1'b1; end
        endcase
        @(negedge clk);
        rirr_set = '0; busy_set = '0; busy_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        bus_rd(8'h00, 32'h0, "R9");
        check("R9", 32'(pin_mask), 32'(24'hFFFFFF));
        check("R9", 32'(pin_remote_irr | pin_busy), 32'h0);
        check("R9", 32'(mask_chg_valid), 32'h0);
        bus_rd(8'h10, 32'h0, "R9");   // identifier zero

        foreach (VECS[i]) begin
            if (VECS[i].rd)
                bus_rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d", VECS[i].req));
            else
                bus_wr(VECS[i].addr, VECS[i].data);
        end

        // R12 per-pin outputs of entry 1
        check("R12", 32'(pin_vector[8 +: 8]), 32'h34);
        check("R12", 32'(pin_dlv_mode[3 +: 3]), 32'h2);
        check("R12", 32'({pin_trigger[1], pin_polarity[1], pin_mask[1], pin_dest_mode[1]}), 32'b1100);
        check("R12", 32'(pin_dest[8 +: 8]), 32'h7E);
        check("R12", 32'(pin_dest[23*8 +: 8]), 32'hAA);

        // R10 mask strobe on entry 2
        bus_wr(8'h00, 32'h14);
        bus_wr(8'h10, 32'h00000000);
        check("R10", 32'({mask_chg_valid, mask_chg_pin}), {26'h0, 1'b1, 5'd2});
        @(negedge clk);
        check("R10", 32'(mask_chg_valid), 32'h0);
        bus_wr(8'h10, 32'h00000055);
        check("R10", 32'(mask_chg_valid), 32'h0);

        // R7 remote-IRR survives writes on a level entry
        bus_wr(8'h00, 32'h12);
        pulse_status(0, 1);
        bus_rd(8'h10, 32'h0000E234, "R7");
        bus_wr(8'h10, 32'h0000A234);
        bus_rd(8'h10, 32'h0000E234, "R7");
        bus_wr(8'h00, 32'h13);
        bus_wr(8'h10, 32'h7E000000);
        check("R7", 32'(pin_remote_irr[1]), 32'h1);

        // R8 switching to edge clears remote-IRR
        bus_wr(8'h00, 32'h12);
        bus_wr(8'h10, 32'h00002234);
        bus_rd(8'h10, 32'h00002234, "R8");
        check("R8", 32'(pin_remote_irr[1]), 32'h0);

        // R7 busy status set, survives, clear wins
        pulse_status(1, 1);
        bus_wr(8'h10, 32'h00000234);
        bus_rd(8'h10, 32'h00001234, "R7");
        pulse_status(2, 1);
        bus_rd(8'h10, 32'h00000234, "R7");

        // R5 out-of-range writes leave entries alone
        bus_wr(8'h00, 32'h41);
        bus_wr(8'h10, 32'hFFFFFFFF);
        check("R5", 32'(pin_dest[23*8 +: 8]), 32'hAA);
        check("R5", 32'(mask_chg_valid), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule